// File: doc/BRIEF.md
# Audio-Link Transmit Sample Buffer

This block sits between a DMA engine and one outgoing slot of a serial audio codec link. While its stream is switched on it holds a request line toward the DMA side whenever it has a free entry, and it accepts one sample word per accepted write. Once per frame the link side asks for a sample. The block answers one cycle later with a valid flag and a data word.

After the stream is switched on, the buffer first fills up completely before it hands out any data. During that prefill phase it deliberately answers every link request as not valid. The DMA transfer size must therefore be at least the buffer depth. Once the buffer has been full once, asking it for a sample while it is empty is an underrun. The answer is then an all-zero slot, and a sticky error flag is set. If the halt option is on, the underrun also stops the stream. The only way out of a halt is to switch the stream off, which empties the buffer, and then on again, which starts a new prefill.

The buffer depth follows from the kind of stream the instance serves:

| Stream kind | Depth (words) |
|---|---|
| Front pair | 3 |
| Surround pair | 3 |
| Center | 2 |
| Low-frequency | 2 |
| Modem | 1 |

Top module: `slot_tx_fifo`

## Requirements
- R1: `dma_req_o` is high in the cycle after a clock edge where the stream is enabled, not halted and the buffer holds fewer than DEPTH words; otherwise it is low. A write strobe is accepted only while `dma_req_o` is high; a strobe while it is low stores nothing.
- R2: Once the buffer has been full once, a link request made while it holds data sets `slot_valid_o` to 1 in the next cycle, with `slot_data_o` equal to the oldest stored word, which is then removed.
- R3: Before the buffer has been full once since enable, a link request is answered with `slot_valid_o` = 0, removes nothing and does not set `underrun_o`.
- R4: Once the buffer has been full once, a link request made while it is empty is answered with `slot_valid_o` = 0 and sets `underrun_o` to 1 in the next cycle.
- R5: Whenever `slot_valid_o` is 0, every bit of `slot_data_o` is 0.
- R6: `underrun_o` stays set until the cycle after `err_clr_i` is high or the stream is disabled. A new underrun in the same cycle as `err_clr_i` wins, and `underrun_o` stays 1.
- R7: With `halt_en_i` high, an underrun halts the stream. From the next cycle `dma_req_o` is low, writes are ignored and link requests get `slot_valid_o` = 0. This lasts until `en_i` goes low.
- R8: In the cycle after a clock edge with `en_i` low, the buffer is empty, `dma_req_o`, `underrun_o`, `slot_valid_o` and `slot_data_o` are all 0, the halt is released and prefill is armed again. The same state follows reset.
- R9: DEPTH follows from the stream-kind parameter: 3 for front and surround pairs, 2 for center and low-frequency, 1 for modem. Starting empty, `dma_req_o` falls right after exactly DEPTH accepted writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Stream enable; low flushes and re-arms prefill |
| halt_en_i | input | 1 | Halt the stream on underrun |
| err_clr_i | input | 1 | Write-one-to-clear strobe for the underrun flag |
| dma_wr_i | input | 1 | DMA write strobe |
| dma_data_i | input | DATA_W | DMA write data |
| dma_req_o | output | 1 | Request toward DMA (room available) |
| link_req_i | input | 1 | Link asks for one sample |
| slot_valid_o | output | 1 | Answer valid flag |
| slot_data_o | output | DATA_W | Answer data, zero when not valid |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
The bench builds two instances side by side with 20-bit words: a front-pair instance of depth 3 and a modem instance of depth 1. The depth-3 instance brings a prefill that spans several writes, and pops that overlap with writes when the buffer is partly full. The depth-1 instance is full after one write and empty after one pop. In that instance the full and empty edges, and write strobes while the request is low, occur nearly every frame, so the buffer edges are exercised on every random cycle.

// File: rtl/slot_fifo_pkg.sv
package slot_fifo_pkg;

  typedef enum logic [2:0] {
    SK_FRONT,
    SK_SURROUND,
    SK_CENTER,
    SK_LFE,
    SK_MODEM
  } stream_kind_e;

  // Buffer depth in words for each stream kind (R9)
  function automatic int unsigned depth_of(stream_kind_e kind);
    case (kind)
      SK_FRONT, SK_SURROUND: depth_of = 3;
      SK_CENTER, SK_LFE:     depth_of = 2;
      default:               depth_of = 1;
    endcase
  endfunction

endpackage

// File: rtl/slot_fifo_store.sv
module slot_fifo_store #(
  parameter int unsigned DATA_W = 20,
  parameter int unsigned DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d;
  logic [PTR_W-1:0]  rd_q, rd_d;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    bump = (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d = wr_q;
    rd_d = rd_q;
    if (flush_i) begin
      wr_d = '0;
      rd_d = '0;
    end else begin
      if (push_i) wr_d = bump(wr_q);
      if (pop_i)  rd_d = bump(rd_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  // Storage entries without reset, one write enable each
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (push_i && (wr_q == PTR_W'(g))) mem_q[g] <= wdata_i;
    end
  end

  if (DEPTH == 1) begin : g_single
    assign rdata_o = mem_q[0];
  end else begin : g_multi
    assign rdata_o = mem_q[rd_q];
  end

  p_ptr_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q <= LAST) && (rd_q <= LAST));

  p_flush_resets_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (wr_q == '0) && (rd_q == '0));

endmodule

// File: rtl/slot_fifo_ctrl.sv
module slot_fifo_ctrl #(
  parameter int unsigned DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic halt_en_i,
  input  logic err_clr_i,
  input  logic dma_wr_i,
  input  logic link_req_i,
  output logic flush_o,
  output logic push_o,
  output logic pop_o,
  output logic dma_req_o,
  output logic underrun_o
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic primed_q, primed_d;
  logic halt_q, halt_d;
  logic und_q, und_d;
  logic req_q, req_d;
  logic active, under;

  always_comb begin
    active  = en_i && !halt_q;
    flush_o = !en_i;
    push_o  = active && dma_wr_i && req_q;
    pop_o   = active && link_req_i && primed_q && (cnt_q != '0);
    under   = active && link_req_i && primed_q && (cnt_q == '0);

    cnt_d = cnt_q;
    if (push_o && !pop_o)      cnt_d = cnt_q + 1'b1;
    else if (pop_o && !push_o) cnt_d = cnt_q - 1'b1;

    primed_d = primed_q || (cnt_d == FULL);
    halt_d   = halt_q || (under && halt_en_i);

    und_d = und_q;
    if (under)          und_d = 1'b1;
    else if (err_clr_i) und_d = 1'b0;

    if (flush_o) begin
      cnt_d    = '0;
      primed_d = 1'b0;
      halt_d   = 1'b0;
      und_d    = 1'b0;
    end

    req_d = en_i && !halt_d && (cnt_d < FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
      halt_q   <= 1'b0;
      und_q    <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      primed_q <= primed_d;
      halt_q   <= halt_d;
      und_q    <= und_d;
      req_q    <= req_d;
    end
  end

  assign dma_req_o  = req_q;
  assign underrun_o = und_q;

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (cnt_q < FULL));

  p_prefill_no_error_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(und_q) |-> $past(primed_q));

  p_underrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (und_q && en_i && !err_clr_i) |=> und_q);

  p_halt_blocks_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> !req_q);

  p_disable_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0) && !req_q && !und_q && !primed_q);

endmodule

// File: rtl/slot_tx_fifo.sv
module slot_tx_fifo #(
  parameter slot_fifo_pkg::stream_kind_e KIND = slot_fifo_pkg::SK_FRONT,
  parameter int unsigned DATA_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              halt_en_i,
  input  logic              err_clr_i,
  input  logic              dma_wr_i,
  input  logic [DATA_W-1:0] dma_data_i,
  output logic              dma_req_o,
  input  logic              link_req_i,
  output logic              slot_valid_o,
  output logic [DATA_W-1:0] slot_data_o,
  output logic              underrun_o
);

  localparam int unsigned DEPTH = slot_fifo_pkg::depth_of(KIND);

  logic flush, push, pop;
  logic [DATA_W-1:0] rdata;
  logic sv_q, sv_d;
  logic [DATA_W-1:0] sd_q, sd_d;
  logic slot_ld;

  slot_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .halt_en_i  (halt_en_i),
    .err_clr_i  (err_clr_i),
    .dma_wr_i   (dma_wr_i),
    .link_req_i (link_req_i),
    .flush_o    (flush),
    .push_o     (push),
    .pop_o      (pop),
    .dma_req_o  (dma_req_o),
    .underrun_o (underrun_o)
  );

  slot_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (flush),
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (dma_data_i),
    .rdata_o (rdata)
  );

  // Slot answer register: loads on a link request, zeroed while disabled
  always_comb begin
    slot_ld = flush || link_req_i;
    sv_d    = !flush && pop;
    sd_d    = sv_d ? rdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv_q <= 1'b0;
      sd_q <= '0;
    end else if (slot_ld) begin
      sv_q <= sv_d;
      sd_q <= sd_d;
    end
  end

  assign slot_valid_o = sv_q;
  assign slot_data_o  = sd_q;

  p_zero_when_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_valid_o |-> (slot_data_o == '0));

  p_valid_needs_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_valid_o) |-> $past(link_req_i));

  p_underrun_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun_o) |-> !slot_valid_o);

endmodule

// File: tb/slot_tx_fifo_tb_top.sv
`timescale 1ns/1ps
module slot_tx_fifo_tb_top;

  localparam int DW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 1'b0, halt_en_i = 1'b0, err_clr_i = 1'b0;
  logic dma_wr_i = 1'b0, link_req_i = 1'b0;
  logic [DW-1:0] dma_data_i = '0;

  logic          req [2];
  logic          sv  [2];
  logic [DW-1:0] sd  [2];
  logic          ur  [2];

  always #2.5 clk = ~clk;

  slot_tx_fifo #(.KIND(slot_fifo_pkg::SK_FRONT), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .halt_en_i(halt_en_i),
    .err_clr_i(err_clr_i), .dma_wr_i(dma_wr_i), .dma_data_i(dma_data_i),
    .dma_req_o(req[0]), .link_req_i(link_req_i), .slot_valid_o(sv[0]),
    .slot_data_o(sd[0]), .underrun_o(ur[0]));

  slot_tx_fifo #(.KIND(slot_fifo_pkg::SK_MODEM), .DATA_W(DW)) dut_m_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .halt_en_i(halt_en_i),
    .err_clr_i(err_clr_i), .dma_wr_i(dma_wr_i), .dma_data_i(dma_data_i),
    .dma_req_o(req[1]), .link_req_i(link_req_i), .slot_valid_o(sv[1]),
    .slot_data_o(sd[1]), .underrun_o(ur[1]));

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Reference model state, one slot per instance
  int          dep [2] = '{3, 1};
  int          m_cnt [2];
  logic [DW-1:0] m_q [2][4];
  bit          m_primed [2], m_halt [2], m_und [2], m_req [2], m_sv [2];
  logic [DW-1:0] m_sd [2];

  task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      m_cnt[k] = 0; m_primed[k] = 0; m_halt[k] = 0; m_und[k] = 0;
      m_req[k] = 0; m_sv[k] = 0; m_sd[k] = '0;
    end
  endtask

  task automatic model_step(int k, bit en, bit halt, bit clr, bit wr, bit lreq,
                            logic [DW-1:0] d);
    bit push, pop, under;
    if (!en) begin
      m_cnt[k] = 0; m_primed[k] = 0; m_halt[k] = 0; m_und[k] = 0;
      m_req[k] = 0; m_sv[k] = 0; m_sd[k] = '0;
      return;
    end
    push  = !m_halt[k] && wr && m_req[k];
    pop   = !m_halt[k] && lreq && m_primed[k] && (m_cnt[k] > 0);
    under = !m_halt[k] && lreq && m_primed[k] && (m_cnt[k] == 0);
    if (lreq) begin
      m_sv[k] = pop;
      m_sd[k] = pop ? m_q[k][0] : '0;
    end
    if (pop) begin
      for (int i = 0; i < 3; i++) m_q[k][i] = m_q[k][i+1];
      m_cnt[k]--;
    end
    if (push) begin
      m_q[k][m_cnt[k]] = d;
      m_cnt[k]++;
    end
    if (m_cnt[k] == dep[k]) m_primed[k] = 1;
    if (under && halt) m_halt[k] = 1;
    if (under) m_und[k] = 1;
    else if (clr) m_und[k] = 0;
    m_req[k] = !m_halt[k] && (m_cnt[k] < dep[k]);
  endtask

  // One clock: drive at negedge, sample 1 ns after the rising edge
  task automatic cyc(bit en, bit halt, bit clr, bit wr, bit lreq, logic [DW-1:0] d);
    @(negedge clk);
    en_i = en; halt_en_i = halt; err_clr_i = clr;
    dma_wr_i = wr; link_req_i = lreq; dma_data_i = d;
    @(posedge clk);
    #1;
    for (int k = 0; k < 2; k++) begin
      model_step(k, en, halt, clr, wr, lreq, d);
      chk("R1", "dma_req", 32'(req[k]), 32'(m_req[k]));
      chk("R2", "slot_valid", 32'(sv[k]), 32'(m_sv[k]));
      chk("R5", "slot_data", 32'(sd[k]), 32'(m_sd[k]));
      chk("R6", "underrun", 32'(ur[k]), 32'(m_und[k]));
    end
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    chk("R8", "reset dma_req", 32'(req[0]), 0);
    chk("R8", "reset slot_valid", 32'(sv[0]), 0);
    chk("R8", "reset underrun", 32'(ur[0]), 0);
    @(negedge clk);
    rst_n = 1'b1;

    cyc(1, 0, 0, 0, 0, '0);
    chk("R1", "req after enable A", 32'(req[0]), 1);
    chk("R1", "req after enable B", 32'(req[1]), 1);
    cyc(1, 0, 0, 0, 1, '0);
    chk("R3", "prefill answer", 32'(sv[0]), 0);
    chk("R3", "prefill no underrun", 32'(ur[0]), 0);
    cyc(1, 0, 0, 1, 0, 20'h000A1);
    chk("R9", "depth1 full after 1 write", 32'(req[1]), 0);
    chk("R9", "depth3 room after 1 write", 32'(req[0]), 1);
    cyc(1, 0, 0, 1, 0, 20'h000A2);
    chk("R1", "write ignored while req low", 32'(req[1]), 0);
    cyc(1, 0, 0, 1, 0, 20'h000A3);
    chk("R9", "depth3 full after 3 writes", 32'(req[0]), 0);
    cyc(1, 0, 0, 0, 1, '0);
    chk("R2", "A oldest word valid", 32'(sv[0]), 1);
    chk("R2", "A oldest word", 32'(sd[0]), 32'h000A1);
    chk("R2", "B word (A2 ignored)", 32'(sd[1]), 32'h000A1);
    cyc(1, 0, 0, 0, 1, '0);
    chk("R2", "A second word", 32'(sd[0]), 32'h000A2);
    chk("R4", "B underrun answer", 32'(sv[1]), 0);
    chk("R4", "B underrun flag", 32'(ur[1]), 1);
    chk("R5", "B zero data", 32'(sd[1]), 0);
    cyc(1, 0, 0, 0, 0, '0);
    chk("R6", "B underrun held", 32'(ur[1]), 1);
    cyc(1, 0, 1, 0, 0, '0);
    chk("R6", "B underrun cleared", 32'(ur[1]), 0);
    cyc(1, 1, 0, 0, 1, '0);
    chk("R2", "A third word", 32'(sd[0]), 32'h000A3);
    chk("R7", "B halted req low", 32'(req[1]), 0);
    cyc(1, 1, 0, 0, 1, '0);
    chk("R7", "A halted req low", 32'(req[0]), 0);
    chk("R4", "A underrun flag", 32'(ur[0]), 1);
    cyc(1, 1, 0, 1, 1, 20'h000B1);
    chk("R7", "halted answer", 32'(sv[0]), 0);
    chk("R7", "halted write ignored", 32'(req[0]), 0);
    cyc(0, 0, 0, 0, 0, '0);
    chk("R8", "disable clears underrun", 32'(ur[0]), 0);
    chk("R8", "disable drops req", 32'(req[0]), 0);
    cyc(1, 0, 0, 0, 0, '0);
    chk("R8", "re-enable req", 32'(req[0]), 1);
    cyc(1, 0, 0, 0, 1, '0);
    chk("R3", "prefill again", 32'(sv[0]), 0);
    chk("R3", "prefill again no error", 32'(ur[0]), 0);

    // Constrained random phase
    void'($urandom(32'd1234));
    begin
      bit halt;
      halt = 0;
      for (int i = 0; i < 4000; i++) begin
        bit en;
        if (i % 250 == 0) halt = ($urandom % 3) == 0;
        en = ($urandom % 64) != 0;
        cyc(en, halt, ($urandom % 20) == 0, ($urandom % 2) == 0,
            ($urandom % 3) == 0, DW'($urandom));
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(190000 * 5);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule